// File: doc/BRIEF.md
# Asynchronous SRAM Write Cycle Generator

This block is a synchronous bus master that turns single-byte write requests into correctly timed write cycles on a byte-wide asynchronous static RAM. The system side offers an address and a data byte with a request level. The block takes that request when it is free and drives the address. It then pulls chip enable and write enable low together and releases them together, so the later-falling and the earlier-rising edges coincide. Afterwards it holds address and data for the required hold interval. Output enable stays inactive for the whole time, so the RAM never drives the shared data lines while the block does.

Every interval is given as a parameter in nanoseconds, together with the system clock period. The block rounds each interval up to a whole number of clock cycles. The strobe-low phase is stretched to the largest of three limits: the write pulse width, the data setup before the strobes rise, and the address-valid-to-end time. A single-cycle acknowledge reports that the address hold has elapsed. A further request is only taken once the minimum write cycle time has run out. The data-bus drive enable is a separate output that the chip level uses to control its tri-state pad buffers.

Top module: `sram_write_sequencer`

## Requirements
- R1: While reset is active and right after it: chip enable, write enable and output enable are high, the data drive enable is low, the acknowledge is low and the address output is zero.
- R2: A request seen while the block is idle is accepted at that clock edge. The accepted address appears on the bus in the next cycle, with both strobes still high, for N_SETUP = max(1, ceil(T_ADDR_SETUP_NS / CLK_NS)) cycles.
- R3: Chip enable and write enable fall in the same cycle and rise in the same cycle. They stay low for N_STROBE = max(1, ceil(pulse/P), ceil(data setup/P), ceil(addr-to-end/P) − N_SETUP) cycles, where P is CLK_NS.
- R4: The address output does not change from the first setup cycle until the end of the hold phase.
- R5: The data drive enable is high exactly during the strobe-low and hold cycles. The data output does not change while the drive enable is high.
- R6: After the strobes rise, address and data stay driven for N_HOLD = max(1, ceil of each of the two address holds and the data hold over P) cycles.
- R7: The acknowledge is high for exactly one cycle: the first cycle after the hold phase.
- R8: A request is ignored while a cycle is in progress. The next cycle's setup starts no earlier than ceil(T_CYCLE_NS / P) cycles after the previous one's setup started. With the request held high continuously, the acknowledges come exactly that many cycles apart whenever the cycle time is the binding limit.
- R9: Output enable is high at all times.
- R10: Each interval rounds up. With a 20 ns clock, a 50 ns pulse, 30 ns data setup and 60 ns address-to-end, the strobes are low for exactly 3 cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req | input | 1 | Write request level |
| req_addr | input | ADDR_W | Address to write |
| req_data | input | DATA_W | Byte to write |
| ack | output | 1 | One-cycle pulse when the address hold has elapsed |
| sram_addr | output | ADDR_W | RAM address bus |
| sram_dq_out | output | DATA_W | Data toward the RAM data pads |
| sram_dq_oe | output | 1 | Drive enable for the data pads |
| sram_ce_n | output | 1 | Chip enable, active low |
| sram_we_n | output | 1 | Write enable, active low |
| sram_oe_n | output | 1 | Output enable, active low (held inactive) |

## Verification
The bench runs several request patterns and compares every output against a behavioural timeline on every clock:
- A lone write at the lowest address with an all-zero byte.
- Three back-to-back writes with the request held high, using all-ones, alternating and extreme address patterns. This shows whether the recovery gap is honoured and whether acknowledges land exactly one cycle time apart.
- A one-cycle request pulse injected while a write is in progress. This tells a block that correctly ignores busy-time requests from one that latches them.
- A request raised during the recovery gap. This tests that acceptance waits for the idle state rather than dropping the request.

The bench overrides the cycle time so that recovery cycles exist. It also measures the strobe-low length to confirm that the interval rounds up.

// File: rtl/sram_wr_pkg.sv
package sram_wr_pkg;

    typedef enum logic [2:0] {
        PH_IDLE,
        PH_SETUP,
        PH_STROBE,
        PH_HOLD,
        PH_DONE,
        PH_RECOV
    } wr_phase_e;

    // Whole cycles needed to cover a nanosecond interval (rounded up).
    function automatic int ns_to_cyc(input int ns, input int period_ns);
        return (ns + period_ns - 1) / period_ns;
    endfunction

    function automatic int max_of(input int a, input int b);
        return (a > b) ? a : b;
    endfunction

endpackage

// File: rtl/sram_wr_capture.sv
module sram_wr_capture #(
    parameter int ADDR_W = 17,
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load,
    input  logic [ADDR_W-1:0] addr_in,
    input  logic [DATA_W-1:0] data_in,
    output logic [ADDR_W-1:0] addr_out,
    output logic [DATA_W-1:0] data_out
);

    typedef struct packed {
        logic [ADDR_W-1:0] addr;
        logic [DATA_W-1:0] data;
    } cap_t;

    cap_t cap_d, cap_q;

    always_comb begin
        cap_d = cap_q;
        if (load) begin
            cap_d.addr = addr_in;
            cap_d.data = data_in;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cap_q <= '0;
        end else begin
            cap_q <= cap_d;
        end
    end

    assign addr_out = cap_q.addr;
    assign data_out = cap_q.data;

endmodule

// File: rtl/sram_wr_seq.sv
module sram_wr_seq
    import sram_wr_pkg::*;
#(
    parameter int N_SETUP  = 1,
    parameter int N_STROBE = 3,
    parameter int N_HOLD   = 1,
    parameter int N_RECOV  = 0,
    parameter int CNT_W    = 3
) (
    input  logic clk,
    input  logic rst_n,
    input  logic req,
    output logic accept,
    output logic strobe_n,
    output logic drive_en,
    output logic ack
);

    localparam int RECOV_LOAD = (N_RECOV > 0) ? N_RECOV - 1 : 0;

    typedef struct packed {
        wr_phase_e          phase;
        logic [CNT_W-1:0]   cnt;
        logic               strobe_n;
        logic               drive_en;
        logic               ack;
    } seq_t;

    seq_t st_d, st_q;

    always_comb begin
        st_d   = st_q;
        accept = 1'b0;
        case (st_q.phase)
            PH_IDLE: begin
                if (req) begin
                    accept     = 1'b1;
                    st_d.phase = PH_SETUP;
                    st_d.cnt   = CNT_W'(N_SETUP - 1);
                end
            end
            PH_SETUP: begin
                if (st_q.cnt == '0) begin
                    st_d.phase = PH_STROBE;
                    st_d.cnt   = CNT_W'(N_STROBE - 1);
                end else begin
                    st_d.cnt = st_q.cnt - 1'b1;
                end
            end
            PH_STROBE: begin
                if (st_q.cnt == '0) begin
                    st_d.phase = PH_HOLD;
                    st_d.cnt   = CNT_W'(N_HOLD - 1);
                end else begin
                    st_d.cnt = st_q.cnt - 1'b1;
                end
            end
            PH_HOLD: begin
                if (st_q.cnt == '0) begin
                    st_d.phase = PH_DONE;
                    st_d.cnt   = '0;
                end else begin
                    st_d.cnt = st_q.cnt - 1'b1;
                end
            end
            PH_DONE: begin
                st_d.phase = (N_RECOV > 0) ? PH_RECOV : PH_IDLE;
                st_d.cnt   = CNT_W'(RECOV_LOAD);
            end
            PH_RECOV: begin
                if (st_q.cnt == '0) begin
                    st_d.phase = PH_IDLE;
                end else begin
                    st_d.cnt = st_q.cnt - 1'b1;
                end
            end
            default: begin
                st_d.phase = PH_IDLE;
                st_d.cnt   = '0;
            end
        endcase
        // Registered pin values follow the phase being entered.
        st_d.strobe_n = (st_d.phase != PH_STROBE);
        st_d.drive_en = (st_d.phase == PH_STROBE) || (st_d.phase == PH_HOLD);
        st_d.ack      = (st_d.phase == PH_DONE);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '{phase: PH_IDLE, cnt: '0, strobe_n: 1'b1,
                      drive_en: 1'b0, ack: 1'b0};
        end else begin
            st_q <= st_d;
        end
    end

    assign strobe_n = st_q.strobe_n;
    assign drive_en = st_q.drive_en;
    assign ack      = st_q.ack;

    // R7: acknowledge lasts a single cycle
    assert_ack_single_R7: assert property (@(posedge clk) disable iff (!rst_n)
        ack |=> !ack);

    // R5: bus is driven whenever the strobes are low
    assert_drive_in_strobe_R5: assert property (@(posedge clk) disable iff (!rst_n)
        !strobe_n |-> drive_en);

    // R6: data still driven in the first cycle after the strobes rise
    assert_drive_after_rise_R6: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(strobe_n) |-> drive_en);

    // R8: no request is taken while a cycle is in progress
    assert_no_accept_busy_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (!strobe_n || drive_en || ack) |-> !accept);

endmodule

// File: rtl/sram_write_sequencer.sv
module sram_write_sequencer
    import sram_wr_pkg::*;
#(
    parameter int ADDR_W             = 17,
    parameter int DATA_W             = 8,
    parameter int CLK_NS             = 20,
    parameter int T_ADDR_SETUP_NS    = 0,
    parameter int T_WE_PULSE_NS      = 50,
    parameter int T_DATA_SETUP_NS    = 30,
    parameter int T_ADDR_TO_END_NS   = 60,
    parameter int T_ADDR_HOLD_WE_NS  = 5,
    parameter int T_ADDR_HOLD_CE_NS  = 10,
    parameter int T_DATA_HOLD_NS     = 5,
    parameter int T_CYCLE_NS         = 70
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [DATA_W-1:0] req_data,
    output logic              ack,
    output logic [ADDR_W-1:0] sram_addr,
    output logic [DATA_W-1:0] sram_dq_out,
    output logic              sram_dq_oe,
    output logic              sram_ce_n,
    output logic              sram_we_n,
    output logic              sram_oe_n
);

    localparam int N_SETUP  = max_of(1, ns_to_cyc(T_ADDR_SETUP_NS, CLK_NS));
    localparam int N_STROBE = max_of(max_of(1, ns_to_cyc(T_WE_PULSE_NS, CLK_NS)),
                              max_of(ns_to_cyc(T_DATA_SETUP_NS, CLK_NS),
                                     ns_to_cyc(T_ADDR_TO_END_NS, CLK_NS) - N_SETUP));
    localparam int N_HOLD   = max_of(max_of(1, ns_to_cyc(T_DATA_HOLD_NS, CLK_NS)),
                              max_of(ns_to_cyc(T_ADDR_HOLD_WE_NS, CLK_NS),
                                     ns_to_cyc(T_ADDR_HOLD_CE_NS, CLK_NS)));
    localparam int N_CYCLE  = ns_to_cyc(T_CYCLE_NS, CLK_NS);
    // Setup-to-setup span is N_SETUP+N_STROBE+N_HOLD + ack cycle + idle cycle + recovery.
    localparam int N_RECOV  = max_of(0, N_CYCLE - (N_SETUP + N_STROBE + N_HOLD + 2));
    localparam int N_MAX    = max_of(max_of(N_SETUP, N_STROBE), max_of(N_HOLD, N_RECOV));
    localparam int CNT_W    = $clog2(N_MAX + 1);

    logic accept;
    logic strobe_n;

    sram_wr_capture #(
        .ADDR_W (ADDR_W),
        .DATA_W (DATA_W)
    ) u_capture (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (accept),
        .addr_in  (req_addr),
        .data_in  (req_data),
        .addr_out (sram_addr),
        .data_out (sram_dq_out)
    );

    sram_wr_seq #(
        .N_SETUP  (N_SETUP),
        .N_STROBE (N_STROBE),
        .N_HOLD   (N_HOLD),
        .N_RECOV  (N_RECOV),
        .CNT_W    (CNT_W)
    ) u_seq (
        .clk      (clk),
        .rst_n    (rst_n),
        .req      (req),
        .accept   (accept),
        .strobe_n (strobe_n),
        .drive_en (sram_dq_oe),
        .ack      (ack)
    );

    // Both strobes share one register so their edges always coincide.
    assign sram_ce_n = strobe_n;
    assign sram_we_n = strobe_n;
    assign sram_oe_n = 1'b1;

    // Strobe-low run length, for the pulse-width check.
    logic [CNT_W:0] low_run_q;
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            low_run_q <= '0;
        end else if (!sram_we_n) begin
            low_run_q <= low_run_q + 1'b1;
        end else begin
            low_run_q <= '0;
        end
    end

    // R3: strobes stay low for exactly N_STROBE cycles
    assert_pulse_width_R3: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(sram_we_n) |-> (low_run_q == (CNT_W+1)'(N_STROBE)));

    // R4: address frozen while strobes are low or data is held
    assert_addr_stable_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (!sram_we_n || sram_dq_oe) |-> $stable(sram_addr));

    // R5: data frozen while it is driven
    assert_data_stable_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (sram_dq_oe && $past(sram_dq_oe)) |-> $stable(sram_dq_out));

    // R2: strobes never fall in the cycle the address changes
    assert_setup_before_fall_R2: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(sram_addr) |-> sram_we_n);

endmodule

// File: tb/sram_write_sequencer_test.sv
module sram_write_sequencer_test;

    localparam int AW    = 17;
    localparam int DW    = 8;
    localparam int P     = 20;
    localparam int TAS   = 0;
    localparam int TWP   = 50;
    localparam int TDS   = 30;
    localparam int TAE   = 60;
    localparam int TAHW  = 5;
    localparam int TAHC  = 10;
    localparam int TDH   = 5;
    localparam int TWC   = 200;

    function automatic int cdiv(input int ns);
        return (ns + P - 1) / P;
    endfunction
    function automatic int mx(input int a, input int b);
        return (a > b) ? a : b;
    endfunction

    localparam int NAS  = mx(1, cdiv(TAS));
    localparam int NWP  = mx(mx(1, cdiv(TWP)), mx(cdiv(TDS), cdiv(TAE) - NAS));
    localparam int NH   = mx(mx(1, cdiv(TDH)), mx(cdiv(TAHW), cdiv(TAHC)));
    localparam int NWC  = cdiv(TWC);
    localparam int NREC = mx(0, NWC - (NAS + NWP + NH) - 2);
    localparam int KEND = NAS + NWP + NH + 1;
    localparam int KFREE = KEND + NREC + 1;
    localparam int KIDLE = 100000;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          req = 1'b0;
    logic [AW-1:0] req_addr = '0;
    logic [DW-1:0] req_data = '0;
    logic          ack;
    logic [AW-1:0] sram_addr;
    logic [DW-1:0] sram_dq_out;
    logic          sram_dq_oe, sram_ce_n, sram_we_n, sram_oe_n;

    sram_write_sequencer #(
        .ADDR_W(AW), .DATA_W(DW), .CLK_NS(P),
        .T_ADDR_SETUP_NS(TAS), .T_WE_PULSE_NS(TWP), .T_DATA_SETUP_NS(TDS),
        .T_ADDR_TO_END_NS(TAE), .T_ADDR_HOLD_WE_NS(TAHW),
        .T_ADDR_HOLD_CE_NS(TAHC), .T_DATA_HOLD_NS(TDH), .T_CYCLE_NS(TWC)
    ) uut (
        .clk(clk), .rst_n(rst_n), .req(req), .req_addr(req_addr),
        .req_data(req_data), .ack(ack), .sram_addr(sram_addr),
        .sram_dq_out(sram_dq_out), .sram_dq_oe(sram_dq_oe),
        .sram_ce_n(sram_ce_n), .sram_we_n(sram_we_n), .sram_oe_n(sram_oe_n)
    );

    always #10 clk = ~clk;   // 50 MHz

    int vectors = 0;
    int miscompares = 0;
    int cyc = 0;
    bit done = 1'b0;

    // Behavioural reference: position k within the current write.
    int            k = KIDLE;
    logic [AW-1:0] m_addr = '0;
    logic [DW-1:0] m_data = '0;

    always @(posedge clk) begin
        cyc++;
        if (!rst_n) begin
            k = KIDLE;
            m_addr = '0;
            m_data = '0;
        end else if (k >= KFREE && req) begin
            k = 1;
            m_addr = req_addr;
            m_data = req_data;
        end else if (k < KIDLE) begin
            k++;
        end
    end

    task automatic check(input string tag, input string what,
                         input longint act, input longint exp);
        vectors++;
        if (act != exp) begin
            miscompares++;
            $display("FAIL %s %s at cycle %0d: actual %0h expected %0h",
                     tag, what, cyc, act, exp);
        end
    endtask

    // Per-cycle comparison, away from the active edge.
    int low_run = 0;
    int last_run = 0;
    always @(negedge clk) begin
        if (!done) begin
            string tag;
            bit e_low, e_drv, e_ack;
            e_low = (k > NAS) && (k <= NAS + NWP);
            e_drv = (k > NAS) && (k <= NAS + NWP + NH);
            e_ack = (k == KEND);
            if (!rst_n || k == KIDLE) tag = rst_n ? "R8" : "R1";
            else if (k <= NAS) tag = "R2";
            else if (k <= NAS + NWP) tag = "R3";
            else if (k <= NAS + NWP + NH) tag = "R6";
            else if (k == KEND) tag = "R7";
            else tag = "R8";
            check("R9", "oe_n", sram_oe_n, 1);
            check(tag, "ce_n", sram_ce_n, !e_low);
            check(tag, "we_n", sram_we_n, !e_low);
            check((tag == "R1") ? "R1" : "R5", "dq_oe", sram_dq_oe, e_drv);
            check(tag, "ack", ack, e_ack);
            check((tag == "R1") ? "R1" : "R4", "addr", sram_addr, m_addr);
            if (e_drv) check("R5", "dq_out", sram_dq_out, m_data);
            if (!sram_we_n) low_run++;
            else begin
                if (low_run != 0) last_run = low_run;
                low_run = 0;
            end
        end
    end

    task automatic summary_and_end();
        done = 1'b1;
        $display("  == %0d vectors applied, %0d miscompares ==", vectors, miscompares);
        $finish;
    endtask

    // Watchdog: a hung run counts as a failed check.
    always @(posedge clk) begin
        if (cyc > 20000 && !done) begin
            vectors++;
            miscompares++;
            $display("FAIL watchdog at cycle %0d: actual hung expected finished", cyc);
            summary_and_end();
        end
    end

    // Present a request and wait for its acknowledge; returns the ack cycle.
    task automatic write_wait(input logic [AW-1:0] a, input logic [DW-1:0] d,
                              output int ack_cyc);
        req = 1'b1;
        req_addr = a;
        req_data = d;
        do @(negedge clk); while (!ack);
        ack_cyc = cyc;
    endtask

    initial begin
        int t0, t1, t2, t3;
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);

        // Lone write, low address, zero byte (R2..R7).
        write_wait(17'h00000, 8'h00, t0);
        req = 1'b0;
        repeat (15) @(negedge clk);

        // Back-to-back with req held high (R8 spacing).
        write_wait(17'h1FFFF, 8'hFF, t1);
        write_wait(17'h0AAAA, 8'hA5, t2);
        write_wait(17'h15555, 8'h5A, t3);
        req = 1'b0;
        check("R8", "ack spacing 1", t2 - t1, NWC);
        check("R8", "ack spacing 2", t3 - t2, NWC);

        // One-cycle request pulse while busy must be ignored (R8).
        repeat (15) @(negedge clk);
        req = 1'b1; req_addr = 17'h00123; req_data = 8'h3C;
        @(negedge clk);
        req = 1'b0;
        @(negedge clk);
        req = 1'b1; req_addr = 17'h1F000; req_data = 8'hEE;
        @(negedge clk);
        req = 1'b0;
        repeat (15) @(negedge clk);
        check("R8", "addr after busy pulse", sram_addr, 17'h00123);

        // Request raised during recovery waits for idle.
        write_wait(17'h0F0F0, 8'h96, t0);
        req = 1'b0;
        @(negedge clk);
        req = 1'b1; req_addr = 17'h10101; req_data = 8'h69;
        do @(negedge clk); while (!ack);
        req = 1'b0;
        check("R8", "recovery request ack spacing", cyc - t0, NWC);
        repeat (15) @(negedge clk);

        // Rounded-up strobe length for 50/30/60 ns at 20 ns clock.
        check("R10", "strobe low cycles", last_run, 3);

        summary_and_end();
    end

endmodule